// File: doc/BRIEF.md
# Early-Terminating Radix-4 Sequential Multiplier

This block multiplies two W-bit operands and returns the low W bits of the product. It works one operation at a time: a one-cycle start pulse with both operands launches the operation, a busy flag marks the working cycles, and a one-cycle done pulse presents the result. Each working cycle retires the two least significant bits of the second operand (the multiplier). The block stops as soon as the multiplier operand, shifted right, has no set bits left. Small multipliers therefore finish in few cycles, and a full-width multiplier takes the longest.

Latency is a fixed minimum of three cycles plus one cycle for each 2-bit group of the multiplier up to and including its highest nonzero group. A registered cycle count of the last operation is output so that the timing can be checked from outside. The result and the count hold their values until the next operation completes.

Top module: `radix4_iter_mul`

## Requirements
- R1: When done_o is high, product_o equals the low W bits of the product of the op_a_i and op_b_i values sampled with the accepted start pulse.
- R2: Counting the cycle in which start is accepted as cycle 1, done_o is high in cycle 3+n. Here n is the number of 2-bit groups of op_b_i from bit 0 up to its highest nonzero group, which is ceil(bit length of op_b_i / 2).
- R3: A zero op_b_i completes with done_o high in cycle 3 and product_o equal to zero.
- R4: done_o is high for exactly one cycle per operation.
- R5: A start pulse seen while busy_o is low is accepted. busy_o is high from the next cycle up to the cycle before done_o. busy_o and done_o are never high together.
- R6: A start pulse while busy_o is high is ignored. The running operation's result and latency are unchanged, and no second operation begins.
- R7: product_o changes only in the cycle in which done_o is high and otherwise holds its value, including while a later operation is running.
- R8: When done_o is high, cycles_o equals the latency from R2. It holds that value until the next completion.
- R9: A synchronous active-high reset clears busy_o, done_o, product_o and cycles_o to zero and abandons any running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin a multiplication |
| op_a_i | input | W | Multiplicand, sampled with an accepted start |
| op_b_i | input | W | Multiplier, sampled with an accepted start; sets the latency |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | W | Low W bits of the product, held between completions |
| cycles_o | output | $clog2(W/2+4) | Latency of the most recent operation in cycles |

## Verification
The checker watches the handshake every cycle. It confirms that done_o lasts a single cycle and never overlaps busy_o, that an idle start raises busy_o, that busy_o falls only into a done cycle, that product_o and cycles_o move only on completion, and that any reported count lies inside the legal latency range. Whether the product is arithmetically right and whether the latency matches the multiplier's group count are shown only by the bench's scenarios. The same holds for zero and full-width multipliers, for a stray start during an operation, and for a reset in the middle of an operation.

// File: rtl/r4m_pkg.sv
package r4m_pkg;

  // Fixed part of the latency: accept cycle, setup cycle, done cycle.
  localparam int R4M_MIN_LAT = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_ITER = 2'd2
  } r4m_state_e;

endpackage

// File: rtl/r4m_multiples.sv
// Forms the triple of the multiplicand once per operation (during setup).
module r4m_multiples #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a3_o
);
  logic [W-1:0] a2_w;

  assign a2_w = {a_i[W-2:0], 1'b0};
  assign a3_o = a_i + a2_w;
endmodule

// File: rtl/r4m_digit_sel.sv
// Selects 0, A, 2A or 3A for the current radix-4 digit of the multiplier.
module r4m_digit_sel #(
  parameter int W = 32
) (
  input  logic [1:0]   digit_i,
  input  logic [W-1:0] m1_i,
  input  logic [W-1:0] m3_i,
  output logic [W-1:0] addend_o
);
  always_comb begin
    unique case (digit_i)
      2'd0:    addend_o = '0;
      2'd1:    addend_o = m1_i;
      2'd2:    addend_o = {m1_i[W-2:0], 1'b0};
      default: addend_o = m3_i;
    endcase
  end
endmodule

// File: rtl/r4m_ctrl.sv
// Sequencer: idle -> setup -> iterate while multiplier bits remain.
module r4m_ctrl
  import r4m_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        b_zero_i,
  input  logic        b_last_i,
  output r4m_state_e  state_o,
  output logic        accept_o,
  output logic        finish_o,
  output logic [CW-1:0] cnt_o
);
  r4m_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign finish_o = ((state_q == ST_PREP) && b_zero_i) ||
                    ((state_q == ST_ITER) && b_last_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = ST_PREP;
      ST_PREP: state_d = b_zero_i ? ST_IDLE : ST_ITER;
      ST_ITER: if (b_last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o)
        cnt_q <= CW'(2);
      else if (state_q != ST_IDLE)
        cnt_q <= cnt_q + CW'(1);
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/radix4_iter_mul.sv
module radix4_iter_mul
  import r4m_pkg::*;
#(
  parameter  int W  = 32,
  localparam int CW = $clog2(R4M_MIN_LAT + W/2 + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [W-1:0]  op_a_i,
  input  logic [W-1:0]  op_b_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  product_o,
  output logic [CW-1:0] cycles_o
);
  r4m_state_e    state_w;
  logic          accept_w, finish_w;
  logic [CW-1:0] cnt_w;

  logic [W-1:0]  a_q, a3_q, b_q, acc_q, prod_q;
  logic [W-1:0]  a3_w, addend_w, acc_sum_w;
  logic [CW-1:0] cyc_q;
  logic          done_q;
  logic          b_zero_w, b_last_w;

  assign b_zero_w  = (b_q == '0);
  assign b_last_w  = (b_q[W-1:2] == '0);
  assign acc_sum_w = acc_q + addend_w;

  r4m_ctrl #(.CW(CW)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .b_zero_i (b_zero_w),
    .b_last_i (b_last_w),
    .state_o  (state_w),
    .accept_o (accept_w),
    .finish_o (finish_w),
    .cnt_o    (cnt_w)
  );

  r4m_multiples #(.W(W)) i_mult3 (
    .a_i  (a_q),
    .a3_o (a3_w)
  );

  r4m_digit_sel #(.W(W)) i_dsel (
    .digit_i  (b_q[1:0]),
    .m1_i     (a_q),
    .m3_i     (a3_q),
    .addend_o (addend_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      a3_q   <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      prod_q <= '0;
      cyc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        a_q   <= op_a_i;
        b_q   <= op_b_i;
        acc_q <= '0;
      end
      if (state_w == ST_PREP) begin
        a3_q <= a3_w;
      end
      if (state_w == ST_ITER) begin
        acc_q <= acc_sum_w;
        a_q   <= {a_q[W-3:0], 2'b00};
        a3_q  <= {a3_q[W-3:0], 2'b00};
        b_q   <= {2'b00, b_q[W-1:2]};
      end
      if (finish_w) begin
        done_q <= 1'b1;
        prod_q <= acc_sum_w;
        cyc_q  <= cnt_w + CW'(1);
      end
    end
  end

  assign busy_o    = (state_w != ST_IDLE);
  assign done_o    = done_q;
  assign product_o = prod_q;
  assign cycles_o  = cyc_q;
endmodule

// File: rtl/r4m_checker.sv
module r4m_checker #(
  parameter int W  = 32,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [W-1:0]  product_o,
  input logic [CW-1:0] cycles_o
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst || rst_d)
    done_o |=> !done_o);

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst || rst_d)
    !(done_o && busy_o));

  p_start_taken_r5: assert property (@(posedge clk) disable iff (rst || rst_d)
    (start_i && !busy_o) |=> busy_o);

  p_busy_ends_done_r5: assert property (@(posedge clk) disable iff (rst || rst_d)
    $fell(busy_o) |-> done_o);

  p_done_follows_busy_r5: assert property (@(posedge clk) disable iff (rst || rst_d)
    $rose(done_o) |-> $past(busy_o));

  p_prod_hold_r7: assert property (@(posedge clk) disable iff (rst || rst_d)
    !done_o |-> $stable(product_o));

  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst || rst_d)
    !done_o |-> $stable(cycles_o));

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst || rst_d)
    done_o |-> (cycles_o >= CW'(3) && cycles_o <= CW'(3 + W/2)));
endmodule

bind radix4_iter_mul r4m_checker #(.W(W), .CW(CW)) i_r4m_checker (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o),
  .cycles_o  (cycles_o)
);

// File: tb/test_radix4_iter_mul.sv
`timescale 1ns/1ps
module test_radix4_iter_mul;
  localparam int W  = 32;
  localparam int CW = $clog2(3 + W/2 + 1);
  localparam int NV = 10;

  localparam logic [31:0] TA [NV] = '{32'd7, 32'd5, 32'h1234, 32'd9, 32'hFFFFFFFF,
                                      32'h80000000, 32'hDEADBEEF, 32'd3, 32'h12345678, 32'd0};
  localparam logic [31:0] TB [NV] = '{32'd0, 32'd1, 32'd3, 32'd4, 32'hFFFFFFFF,
                                      32'd2, 32'h00010000, 32'h40000000, 32'h9ABCDEF0, 32'h55};
  localparam int          TL [NV] = '{3, 4, 4, 5, 19, 4, 12, 19, 19, 7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic busy, done;
  logic [W-1:0] product;
  logic [CW-1:0] cycles;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  radix4_iter_mul #(.W(W)) i_radix4_iter_mul (
    .clk(clk), .rst(rst), .start_i(start), .op_a_i(op_a), .op_b_i(op_b),
    .busy_o(busy), .done_o(done), .product_o(product), .cycles_o(cycles)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input int lat, input bit poke);
    logic [63:0] full;
    int k;
    full = {32'd0, a} * {32'd0, b};
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0; k = 2;
    check(busy == 1'b1, "R5 busy after accepted start", busy, 1);
    if (poke) begin
      start = 1'b1; op_a = 32'h0000_0011; op_b = 32'h3;
      @(negedge clk);
      start = 1'b0; k++;
      check(busy == 1'b1 && done == 1'b0, "R6 busy kept during stray start", busy, 1);
    end
    while (!done && k < 64) begin
      @(negedge clk);
      k++;
    end
    check(k == lat, "R2 done cycle", k, lat);
    check(product == full[31:0], "R1 product low word", product, full[31:0]);
    check(cycles == CW'(lat), "R8 reported cycles", cycles, lat);
    check(busy == 1'b0, "R5 busy low in done cycle", busy, 0);
    if (b == 32'd0)
      check(k == 3 && product == 32'd0, "R3 zero multiplier", product, 0);
    @(negedge clk);
    check(done == 1'b0, "R4 done single cycle", done, 0);
    if (poke)
      check(busy == 1'b0, "R6 stray start not accepted", busy, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [W-1:0] held_p;
    logic [CW-1:0] held_c;
    bit seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0, "R9 reset flags", {busy, done}, 0);
    check(product == 0 && cycles == 0, "R9 reset outputs", product, 0);

    for (int i = 0; i < NV; i++)
      run_op(TA[i], TB[i], TL[i], 1'b0);

    // stray start while busy (R6)
    run_op(32'h0000_0101, 32'h0000_FFFF, 11, 1'b1);

    // hold after completion (R7, R8)
    held_p = product; held_c = cycles;
    repeat (5) @(negedge clk);
    check(product == held_p, "R7 product held when idle", product, held_p);
    check(cycles == held_c, "R8 cycles held when idle", cycles, held_c);

    // product held while the next operation runs (R7)
    start = 1'b1; op_a = 32'd1000; op_b = 32'hFF;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(product == held_p, "R7 product held while busy", product, held_p);
    check(cycles == held_c, "R8 cycles held while busy", cycles, held_c);
    while (!done) @(negedge clk);
    check(product == 32'd255000, "R1 product after hold test", product, 255000);

    // reset mid-operation (R9)
    @(negedge clk);
    start = 1'b1; op_a = 32'd77; op_b = 32'hFFFF_0000;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy == 0 && done == 0, "R9 mid-op reset flags", {busy, done}, 0);
    check(product == 0 && cycles == 0, "R9 mid-op reset outputs", product, 0);
    seen = 1'b0;
    repeat (25) begin
      @(negedge clk);
      if (done || busy) seen = 1'b1;
    end
    check(!seen, "R9 abandoned operation stays quiet", seen, 0);

    run_op(32'h0000_0003, 32'h0000_0007, 5, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule